// File: doc/BRIEF.md
# Vector Register Group Alignment Checker

This block sits in the decode stage of a vector unit and decides, for instructions that work on element groups, whether the decoded register indices are legal. It takes the destination index and two source indices, a valid flag for each, the current register-group multiplier in its 3-bit encoded form, and a flag that marks the vector-scalar form. It then computes the effective multiplier for each operand and tests whether each enabled index is a multiple of that multiplier.

In the vector-vector form all three operands follow the multiplier in effect. In the vector-scalar form the second source instead holds a 128-bit scalar element group. That operand is aligned to its own multiplier, which is 128 divided by the vector register length, with a floor of one. This multiplier does not depend on the global setting. A vector register length of 32 therefore forces a multiple of four, a length of 64 forces an even index, and a length of 128 or more accepts any index.

The result is registered on the clock edge that samples the decode strobe. It is an illegal-instruction flag plus a per-operand fault vector that names the offending operands. Between strobes the result holds its value. The register length is an elaboration-time parameter, restricted to a power of two from 32 to 1024.

Top module: `vreg_group_align_chk`

## Requirements
- R1: `illegal_o` and `fault_o` change only on a rising clock edge at which `dec_valid_i` is high; at every other edge they keep their value.
- R2: While `rst_n` is low, `illegal_o` and `fault_o` are zero.
- R3: For multiplier codes 000, 001, 010 and 011 (group sizes 1, 2, 4 and 8), an enabled operand that follows the global multiplier faults when its 5-bit index is not a multiple of the group size. Destination and first source always follow it. The second source follows it in the vector-vector form (`vs_form_i` = 0).
- R4: Fractional multiplier codes 101, 110 and 111 count as a group size of one, so they never cause a fault on an operand that follows the global multiplier.
- R5: The reserved multiplier code 100 sets `illegal_o`. Operands that follow the global multiplier report no fault under it.
- R6: In the vector-scalar form (`vs_form_i` = 1), an enabled second source faults when its index is not a multiple of max(1, 128/VLEN). This rule holds whatever the multiplier code is.
- R7: An operand whose enable input is low never sets its fault bit.
- R8: `fault_o` bit 0 reports the destination, bit 1 the first source and bit 2 the second source. `illegal_o` is set exactly when a fault bit is set or the code was 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decode strobe; the result is captured at this edge |
| vlmul_i | input | 3 | Encoded register-group multiplier |
| vs_form_i | input | 1 | 1 = vector-scalar form, second source holds a 128-bit scalar group |
| vd_en_i | input | 1 | Destination index is used |
| vs1_en_i | input | 1 | First source index is used |
| vs2_en_i | input | 1 | Second source index is used |
| vd_idx_i | input | 5 | Destination register index |
| vs1_idx_i | input | 5 | First source register index |
| vs2_idx_i | input | 5 | Second source register index |
| illegal_o | output | 1 | Illegal-instruction flag |
| fault_o | output | 3 | Faulting operands: bit 0 destination, bit 1 first source, bit 2 second source |

## Verification
The hardest behaviour to reach is the scalar-group rule for register lengths under 128. The register length is fixed at elaboration, so no port stimulus on a single instance can show both the relaxed case and the strict case. The bench therefore builds three copies with lengths 128, 64 and 32 and drives them with the same inputs. Each table row carries a separate expected result for each length, so a single vector-scalar index such as 2 is shown accepted by the first two copies and rejected by the third.

// File: rtl/vgac_pkg.sv
package vgac_pkg;

    localparam int unsigned IDX_W      = 5;
    localparam int unsigned NUM_OPS    = 3;
    localparam int unsigned SCALAR_EGW = 128;
    localparam int unsigned LOG2_W     = 2;

    localparam int unsigned OP_VD  = 0;
    localparam int unsigned OP_VS1 = 1;
    localparam int unsigned OP_VS2 = 2;

    typedef enum logic [2:0] {
        GRP_X1   = 3'b000,
        GRP_X2   = 3'b001,
        GRP_X4   = 3'b010,
        GRP_X8   = 3'b011,
        GRP_RSVD = 3'b100,
        GRP_F8   = 3'b101,
        GRP_F4   = 3'b110,
        GRP_F2   = 3'b111
    } grp_mul_e;

    function automatic int unsigned scalar_grp_log2(input int unsigned vlen);
        if (vlen >= SCALAR_EGW) begin
            return 0;
        end
        return $clog2(SCALAR_EGW / vlen);
    endfunction

endpackage

// File: rtl/vgac_mul_decode.sv
module vgac_mul_decode
    import vgac_pkg::*;
(
    input  grp_mul_e              code_i,
    output logic [LOG2_W-1:0]     log2_o,
    output logic                  rsvd_o
);

    always_comb begin
        log2_o = '0;
        rsvd_o = 1'b0;
        unique case (code_i)
            GRP_X1:   log2_o = 2'd0;
            GRP_X2:   log2_o = 2'd1;
            GRP_X4:   log2_o = 2'd2;
            GRP_X8:   log2_o = 2'd3;
            GRP_RSVD: rsvd_o = 1'b1;
            GRP_F8, GRP_F4, GRP_F2: log2_o = 2'd0;
            default:  rsvd_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/vgac_align_check.sv
module vgac_align_check
    import vgac_pkg::*;
#(
    parameter int unsigned W = IDX_W
) (
    input  logic [W-1:0]      idx_i,
    input  logic              en_i,
    input  logic [LOG2_W-1:0] log2_i,
    output logic              misaligned_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] low_mask;

    always_comb begin
        low_mask     = (ONE << log2_i) - ONE;
        misaligned_o = en_i && ((idx_i & low_mask) != '0);
    end

endmodule

// File: rtl/vreg_group_align_chk.sv
module vreg_group_align_chk
    import vgac_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid_i,
    input  logic [2:0]       vlmul_i,
    input  logic             vs_form_i,
    input  logic             vd_en_i,
    input  logic             vs1_en_i,
    input  logic             vs2_en_i,
    input  logic [IDX_W-1:0] vd_idx_i,
    input  logic [IDX_W-1:0] vs1_idx_i,
    input  logic [IDX_W-1:0] vs2_idx_i,
    output logic             illegal_o,
    output logic [2:0]       fault_o
);

    localparam int unsigned       SCALAR_L2_INT = scalar_grp_log2(VLEN);
    localparam logic [LOG2_W-1:0] SCALAR_L2     = LOG2_W'(SCALAR_L2_INT);

    initial begin
        p_vlen_legal: assert (VLEN >= 32 && VLEN <= 1024 && (VLEN & (VLEN - 1)) == 0)
            else $error("VLEN must be a power of two from 32 to 1024");
    end

    logic [LOG2_W-1:0]  glob_log2;
    logic               glob_rsvd;
    logic [IDX_W-1:0]   op_idx   [NUM_OPS];
    logic [NUM_OPS-1:0] op_en;
    logic [NUM_OPS-1:0] fault_d;
    logic               illegal_d;

    vgac_mul_decode u_mul_decode (
        .code_i (grp_mul_e'(vlmul_i)),
        .log2_o (glob_log2),
        .rsvd_o (glob_rsvd)
    );

    always_comb begin
        op_idx[OP_VD]  = vd_idx_i;
        op_idx[OP_VS1] = vs1_idx_i;
        op_idx[OP_VS2] = vs2_idx_i;
        op_en[OP_VD]   = vd_en_i;
        op_en[OP_VS1]  = vs1_en_i;
        op_en[OP_VS2]  = vs2_en_i;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic              scalar_grp;
        logic [LOG2_W-1:0] op_log2;
        logic              op_chk_en;
        logic              op_bad;

        // Only the second source of the vector-scalar form takes the scalar group size.
        assign scalar_grp = (g == OP_VS2) && vs_form_i;
        assign op_log2    = scalar_grp ? SCALAR_L2 : glob_log2;
        // Under the reserved code the global size is meaningless; only the flag reports it.
        assign op_chk_en  = op_en[g] && (scalar_grp || !glob_rsvd);

        vgac_align_check #(.W(IDX_W)) u_align (
            .idx_i        (op_idx[g]),
            .en_i         (op_chk_en),
            .log2_i       (op_log2),
            .misaligned_o (op_bad)
        );

        assign fault_d[g] = op_bad;
    end

    assign illegal_d = (|fault_d) || glob_rsvd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            illegal_o <= 1'b0;
            fault_o   <= '0;
        end else if (dec_valid_i) begin
            illegal_o <= illegal_d;
            fault_o   <= fault_d;
        end
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(illegal_o) && $stable(fault_o)));

    p_frac_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && vlmul_i[2] && (vlmul_i != 3'b100) && !vs_form_i) |=> (fault_o == 3'b000));

    p_rsvd_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && (vlmul_i == 3'b100)) |=> illegal_o);

    p_scalar_quad_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && vs_form_i && (vs2_idx_i[1:0] == 2'b00)) |=> !fault_o[OP_VS2]);

    p_disabled_vd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && !vd_en_i) |=> !fault_o[OP_VD]);

    p_disabled_vs1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && !vs1_en_i) |=> !fault_o[OP_VS1]);

    p_disabled_vs2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && !vs2_en_i) |=> !fault_o[OP_VS2]);

    p_flag_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> (illegal_o == ((|fault_o) || ($past(vlmul_i) == 3'b100))));

endmodule

// File: tb/test_vreg_group_align_chk.sv
module test_vreg_group_align_chk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [2:0] vlmul = 3'b000;
    logic       vs_form = 1'b0;
    logic       vd_en = 1'b0, vs1_en = 1'b0, vs2_en = 1'b0;
    logic [4:0] vd = '0, vs1 = '0, vs2 = '0;

    logic       ill_a, ill_b, ill_c;
    logic [2:0] flt_a, flt_b, flt_c;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vreg_group_align_chk #(.VLEN(128)) i_vreg_group_align_chk (
        .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .vlmul_i(vlmul), .vs_form_i(vs_form),
        .vd_en_i(vd_en), .vs1_en_i(vs1_en), .vs2_en_i(vs2_en),
        .vd_idx_i(vd), .vs1_idx_i(vs1), .vs2_idx_i(vs2), .illegal_o(ill_a), .fault_o(flt_a));

    vreg_group_align_chk #(.VLEN(64)) i_vreg_group_align_chk_v64 (
        .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .vlmul_i(vlmul), .vs_form_i(vs_form),
        .vd_en_i(vd_en), .vs1_en_i(vs1_en), .vs2_en_i(vs2_en),
        .vd_idx_i(vd), .vs1_idx_i(vs1), .vs2_idx_i(vs2), .illegal_o(ill_b), .fault_o(flt_b));

    vreg_group_align_chk #(.VLEN(32)) i_vreg_group_align_chk_v32 (
        .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid), .vlmul_i(vlmul), .vs_form_i(vs_form),
        .vd_en_i(vd_en), .vs1_en_i(vs1_en), .vs2_en_i(vs2_en),
        .vd_idx_i(vd), .vs1_idx_i(vs1), .vs2_idx_i(vs2), .illegal_o(ill_c), .fault_o(flt_c));

    // Row: {code[3], vs_form, en{vs2,vs1,vd}, vd[5], vs1[5], vs2[5], exp128[4], exp64[4], exp32[4]}
    // Expected nibble = {illegal, fault[2:0]} with fault bit0 vd, bit1 vs1, bit2 vs2.
    localparam int NROW = 17;
    localparam logic [33:0] VEC [NROW] = '{
        {3'b000, 1'b0, 3'b111, 5'd3,  5'd5,  5'd7,  4'h0, 4'h0, 4'h0}, // R3 size 1
        {3'b001, 1'b0, 3'b111, 5'd2,  5'd3,  5'd4,  4'hA, 4'hA, 4'hA}, // R3 vs1 odd
        {3'b010, 1'b0, 3'b111, 5'd4,  5'd8,  5'd6,  4'hC, 4'hC, 4'hC}, // R3 vs2 in vv
        {3'b011, 1'b0, 3'b111, 5'd8,  5'd16, 5'd24, 4'h0, 4'h0, 4'h0}, // R3 size 8 aligned
        {3'b011, 1'b0, 3'b111, 5'd12, 5'd9,  5'd31, 4'hF, 4'hF, 4'hF}, // R3 R8 all bad
        {3'b101, 1'b0, 3'b111, 5'd1,  5'd3,  5'd5,  4'h0, 4'h0, 4'h0}, // R4
        {3'b111, 1'b0, 3'b111, 5'd31, 5'd7,  5'd13, 4'h0, 4'h0, 4'h0}, // R4
        {3'b100, 1'b0, 3'b111, 5'd0,  5'd0,  5'd0,  4'h8, 4'h8, 4'h8}, // R5
        {3'b011, 1'b1, 3'b111, 5'd8,  5'd16, 5'd1,  4'h0, 4'hC, 4'hC}, // R6 odd scalar
        {3'b011, 1'b1, 3'b111, 5'd8,  5'd0,  5'd2,  4'h0, 4'h0, 4'hC}, // R6 index 2
        {3'b000, 1'b1, 3'b111, 5'd5,  5'd3,  5'd6,  4'h0, 4'h0, 4'hC}, // R6
        {3'b001, 1'b1, 3'b111, 5'd4,  5'd2,  5'd12, 4'h0, 4'h0, 4'h0}, // R6 quad aligned
        {3'b011, 1'b0, 3'b000, 5'd1,  5'd2,  5'd3,  4'h0, 4'h0, 4'h0}, // R7 none enabled
        {3'b010, 1'b0, 3'b100, 5'd1,  5'd3,  5'd6,  4'hC, 4'hC, 4'hC}, // R7 only vs2
        {3'b010, 1'b1, 3'b001, 5'd2,  5'd5,  5'd3,  4'h9, 4'h9, 4'h9}, // R7 R8 vd only
        {3'b100, 1'b1, 3'b111, 5'd1,  5'd1,  5'd1,  4'h8, 4'hC, 4'hC}, // R5 R6
        {3'b110, 1'b1, 3'b111, 5'd3,  5'd3,  5'd2,  4'h0, 4'h0, 4'hC}  // R4 R6
    };

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [33:0] r);
        @(negedge clk);
        vlmul = r[33:31]; vs_form = r[30];
        vs2_en = r[29]; vs1_en = r[28]; vd_en = r[27];
        vd = r[26:22]; vs1 = r[21:17]; vs2 = r[16:12];
        dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2", "reset v128", {ill_a, flt_a}, 4'h0);
        chk("R2", "reset v32",  {ill_c, flt_c}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "no strobe after reset", {ill_a, flt_a}, 4'h0);

        for (int i = 0; i < NROW; i++) begin
            drive(VEC[i]);
            chk("R3-R8 row", $sformatf("row %0d v128", i), {ill_a, flt_a}, VEC[i][11:8]);
            chk("R3-R8 row", $sformatf("row %0d v64", i),  {ill_b, flt_b}, VEC[i][7:4]);
            chk("R3-R8 row", $sformatf("row %0d v32", i),  {ill_c, flt_c}, VEC[i][3:0]);
        end

        // R1: load an all-fault result, then change inputs without a strobe.
        drive(VEC[4]);
        @(negedge clk);
        vlmul = 3'b000; vd = 5'd0; vs1 = 5'd0; vs2 = 5'd0; dec_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "hold without strobe", {ill_a, flt_a}, 4'hF);
        dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
        chk("R1", "update on strobe", {ill_a, flt_a}, 4'h0);

        // R2: reset in the middle of operation clears a faulted result.
        drive(VEC[4]);
        chk("R8", "before mid reset", {ill_b, flt_b}, 4'hF);
        rst_n = 1'b0;
        #1;
        chk("R2", "mid reset v64", {ill_b, flt_b}, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "after reset release", {ill_a, flt_a}, 4'h0);

        // R6: scalar index 4 accepted at every length, size-8 global on vd.
        drive({3'b011, 1'b1, 3'b111, 5'd16, 5'd24, 5'd4, 12'h000});
        chk("R6", "index 4 v32", {ill_c, flt_c}, 4'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule